// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32x32 two-color cursor over a scanned pixel stream. A register bus holds the cursor position, 32 transparency words and 32 color-select words (one pair per cursor row), plus a miscellaneous read/write register. On the pixel side the block receives the current scan coordinate, the underlying pixel color and the two cursor colors. It returns either the underlying color or one of the two cursor colors, one clock later.

Each cursor row is a pair of words. The transparency word decides whether the cursor covers a column at all. The color-select word then picks cursor color 0 or 1. The most significant bit of each word maps to the leftmost column of the cursor. A cursor that extends past the right screen edge is clipped. A cursor whose X lies at or beyond the screen width is not drawn. Palette storage and video timing are outside the block; the cursor colors arrive as inputs.

Top module: `cur_overlay`

## Requirements
- R1: `pix_valid_o` equals `pix_valid_i` delayed by exactly one clock, and `pix_color_o` is the result for the pixel presented one clock earlier.
- R2: A write to offset 0x8FC loads cursor X from data bits 31:16 and cursor Y from data bits 15:0.
- R3: Writes to 0x900..0x97F load transparency word r, and writes to 0x980..0x9FF load color-select word r, where r = (offset - region base) >> 2. Address bits 1:0 are ignored.
- R4: Bit 31 of a row word covers column X (the leftmost column), and bit b covers column X + 31 - b.
- R5: Where the transparency bit is 1, the output is `cur_col1_i` if the color-select bit is 1 and `cur_col0_i` if it is 0. Where the transparency bit is 0, `pix_color_i` passes through.
- R6: The cursor covers scan lines Y..Y+31 and columns X..X+31 with no wrap-around. Any pixel outside that window passes through.
- R7: A pixel is overlaid only when cursor X < SCREEN_W, pixel x < SCREEN_W and pixel y < SCREEN_H. Columns beyond the right edge are clipped and pass through.
- R8: Reset puts cursor X and Y at 0xF000 (off screen), clears all row words and the misc register, and holds `pix_valid_o` low.
- R9: Offset 0x818 is read/write. A read returns the stored value with bit 25 forced to 1.
- R10: A read at any offset other than 0x818 returns 0. A write to an offset outside 0x818, 0x8FC and the two row regions changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the offset |
| pix_valid_i | input | 1 | Pixel input valid |
| pix_x_i | input | 16 | Scan column |
| pix_y_i | input | 16 | Scan line |
| pix_color_i | input | 24 | Underlying pixel color |
| cur_col0_i | input | 24 | Cursor color 0 |
| cur_col1_i | input | 24 | Cursor color 1 |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_color_o | output | 24 | Overlaid pixel color |

## Verification
The assertions take two things for granted:
- `pix_valid_i` is low while reset is held.
- The read offset is settled when `reg_rdata_o` is sampled. The read path is combinational, so any register stage at the bus edge belongs to the caller.

The color-membership property is only meaningful when the underlying pixel colors differ from both cursor colors. The stimulus therefore uses pixel colors whose top byte is 0x81 and cursor colors whose top bytes are 0x0F and 0xF0. It changes the offset only at the inactive clock edge and keeps the valid input low through reset.

// File: rtl/cur_pkg.sv
package cur_pkg;
  parameter int OFS_MISC   = 'h818;
  parameter int OFS_POS    = 'h8FC;
  parameter int OFS_MASK   = 'h900;
  parameter int OFS_IMG    = 'h980;
  parameter int MISC_FORCE = 25;
  parameter logic [15:0] OFF_SCREEN = 16'hF000;

  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
  } cur_pos_t;
endpackage

// File: rtl/cur_regs.sv
module cur_regs
  import cur_pkg::*;
#(
  parameter int ROWS   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  localparam int RW    = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [RW-1:0]     row_sel_i,
  output cur_pos_t          pos_o,
  output logic [DATA_W-1:0] mask_row_o,
  output logic [DATA_W-1:0] img_row_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W:0] MASK_LO = (ADDR_W+1)'(OFS_MASK);
  localparam logic [ADDR_W:0] MASK_HI = (ADDR_W+1)'(OFS_MASK + ROWS*4);
  localparam logic [ADDR_W:0] IMG_LO  = (ADDR_W+1)'(OFS_IMG);
  localparam logic [ADDR_W:0] IMG_HI  = (ADDR_W+1)'(OFS_IMG + ROWS*4);

  logic [ADDR_W:0] a_ext;
  logic            mask_hit, img_hit, pos_hit, misc_hit;
  logic [RW-1:0]   widx;
  logic [DATA_W-1:0] misc_q;
  cur_pos_t        pos_q;
  logic [DATA_W-1:0] mask_all [ROWS];
  logic [DATA_W-1:0] img_all  [ROWS];

  assign a_ext    = {1'b0, addr_i};
  assign mask_hit = (a_ext >= MASK_LO) && (a_ext < MASK_HI);
  assign img_hit  = (a_ext >= IMG_LO) && (a_ext < IMG_HI);
  assign pos_hit  = (addr_i == ADDR_W'(OFS_POS));
  assign misc_hit = (addr_i == ADDR_W'(OFS_MISC));
  // region bases are aligned to ROWS*4, so the row index is a plain slice
  assign widx     = addr_i[RW+1:2];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [DATA_W-1:0] m_q, i_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m_q <= '0;
        i_q <= '0;
      end else if (we_i && (widx == RW'(r))) begin
        if (mask_hit) m_q <= wdata_i;
        if (img_hit)  i_q <= wdata_i;
      end
    end
    assign mask_all[r] = m_q;
    assign img_all[r]  = i_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q.x <= OFF_SCREEN;
      pos_q.y <= OFF_SCREEN;
      misc_q  <= '0;
    end else if (we_i) begin
      if (pos_hit) begin
        pos_q.x <= wdata_i[31:16];
        pos_q.y <= wdata_i[15:0];
      end
      if (misc_hit) misc_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (misc_hit) begin
      rdata_o = misc_q;
      rdata_o[MISC_FORCE] = 1'b1;
    end
  end

  assign pos_o      = pos_q;
  assign mask_row_o = mask_all[row_sel_i];
  assign img_row_o  = img_all[row_sel_i];
endmodule

// File: rtl/cur_pick.sv
module cur_pick
  import cur_pkg::*;
#(
  parameter int ROWS     = 32,
  parameter int DATA_W   = 32,
  parameter int COLOR_W  = 24,
  parameter int SCREEN_W = 1024,
  parameter int SCREEN_H = 768,
  localparam int RW      = $clog2(ROWS),
  localparam int CBW     = $clog2(DATA_W)
) (
  input  cur_pos_t           pos_i,
  input  logic [15:0]        x_i,
  input  logic [15:0]        y_i,
  input  logic [COLOR_W-1:0] pix_i,
  input  logic [COLOR_W-1:0] col0_i,
  input  logic [COLOR_W-1:0] col1_i,
  input  logic [DATA_W-1:0]  mask_row_i,
  input  logic [DATA_W-1:0]  img_row_i,
  output logic [RW-1:0]      row_o,
  output logic [COLOR_W-1:0] color_o
);
  localparam logic [16:0] W_LIM = 17'(SCREEN_W);
  localparam logic [16:0] H_LIM = 17'(SCREEN_H);

  logic [16:0]    dx, dy;
  logic           in_x, in_y, on_scr, bit_m, bit_i;
  logic [CBW-1:0] bsel;

  // 17-bit difference: the sign bit rejects pixels left of / above the cursor
  assign dx   = {1'b0, x_i} - {1'b0, pos_i.x};
  assign dy   = {1'b0, y_i} - {1'b0, pos_i.y};
  assign in_x = !dx[16] && (dx[15:0] < 16'(DATA_W));
  assign in_y = !dy[16] && (dy[15:0] < 16'(ROWS));
  assign on_scr = ({1'b0, pos_i.x} < W_LIM) && ({1'b0, x_i} < W_LIM) &&
                  ({1'b0, y_i} < H_LIM);

  assign row_o = dy[RW-1:0];
  assign bsel  = CBW'(DATA_W - 1) - dx[CBW-1:0];
  assign bit_m = mask_row_i[bsel];
  assign bit_i = img_row_i[bsel];

  always_comb begin
    color_o = pix_i;
    if (on_scr && in_x && in_y && bit_m) color_o = bit_i ? col1_i : col0_i;
  end
endmodule

// File: rtl/cur_overlay.sv
module cur_overlay
  import cur_pkg::*;
#(
  parameter int ROWS     = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int COLOR_W  = 24,
  parameter int SCREEN_W = 1024,
  parameter int SCREEN_H = 768
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               pix_valid_i,
  input  logic [15:0]        pix_x_i,
  input  logic [15:0]        pix_y_i,
  input  logic [COLOR_W-1:0] pix_color_i,
  input  logic [COLOR_W-1:0] cur_col0_i,
  input  logic [COLOR_W-1:0] cur_col1_i,
  output logic               pix_valid_o,
  output logic [COLOR_W-1:0] pix_color_o
);
  localparam int RW = $clog2(ROWS);

  cur_pos_t           pos;
  logic [RW-1:0]      row;
  logic [DATA_W-1:0]  mask_row, img_row;
  logic [COLOR_W-1:0] color_d;

  cur_regs #(.ROWS(ROWS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .row_sel_i  (row),
    .pos_o      (pos),
    .mask_row_o (mask_row),
    .img_row_o  (img_row),
    .rdata_o    (reg_rdata_o)
  );

  cur_pick #(
    .ROWS(ROWS), .DATA_W(DATA_W), .COLOR_W(COLOR_W),
    .SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H)
  ) u_pick (
    .pos_i      (pos),
    .x_i        (pix_x_i),
    .y_i        (pix_y_i),
    .pix_i      (pix_color_i),
    .col0_i     (cur_col0_i),
    .col1_i     (cur_col1_i),
    .mask_row_i (mask_row),
    .img_row_i  (img_row),
    .row_o      (row),
    .color_o    (color_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_color_o <= '0;
    end else begin
      pix_valid_o <= pix_valid_i;
      pix_color_o <= color_d;
    end
  end
endmodule

// File: rtl/cur_overlay_chk.sv
module cur_overlay_chk #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int COLOR_W  = 24,
  parameter int SCREEN_W = 1024,
  parameter int SCREEN_H = 768
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic               pix_valid_i,
  input logic [15:0]        pix_x_i,
  input logic [15:0]        pix_y_i,
  input logic [COLOR_W-1:0] pix_color_i,
  input logic [COLOR_W-1:0] cur_col0_i,
  input logic [COLOR_W-1:0] cur_col1_i,
  input logic               pix_valid_o,
  input logic [COLOR_W-1:0] pix_color_o
);
  localparam logic [16:0] W_LIM = 17'(SCREEN_W);
  localparam logic [16:0] H_LIM = 17'(SCREEN_H);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R8: assert (pix_valid_o == 1'b0);
  end

  assert_valid_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (pix_valid_o == $past(pix_valid_i)));

  assert_color_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && pix_valid_o) |->
      (pix_color_o == $past(pix_color_i) || pix_color_o == $past(cur_col0_i) ||
       pix_color_o == $past(cur_col1_i)));

  assert_offscreen_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(pix_valid_i) &&
     ({1'b0, $past(pix_x_i)} >= W_LIM || {1'b0, $past(pix_y_i)} >= H_LIM)) |->
      (pix_color_o == $past(pix_color_i)));

  assert_misc_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'('h818)) |-> reg_rdata_o[25]);

  assert_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != ADDR_W'('h818)) |-> (reg_rdata_o == '0));
endmodule

bind cur_overlay cur_overlay_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COLOR_W(COLOR_W),
  .SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H)
) u_chk (.*);

// File: tb/cur_overlay_bench.sv
`timescale 1ns/1ps
module cur_overlay_bench;
  localparam logic [23:0] COL0 = 24'h0F0F0F;
  localparam logic [23:0] COL1 = 24'hF0F0F0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        pix_valid_i = 1'b0;
  logic [15:0] pix_x_i = '0, pix_y_i = '0;
  logic [23:0] pix_color_i = '0;
  logic        pix_valid_o;
  logic [23:0] pix_color_o;

  always #2 clk = ~clk;

  cur_overlay u_cur_overlay (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pix_valid_i(pix_valid_i),
    .pix_x_i(pix_x_i), .pix_y_i(pix_y_i), .pix_color_i(pix_color_i),
    .cur_col0_i(COL0), .cur_col1_i(COL1), .pix_valid_o(pix_valid_o),
    .pix_color_o(pix_color_o)
  );

  typedef struct {
    logic [23:0] exp;
    string       tag;
    int          x;
    int          y;
  } item_t;

  item_t       exp_q[$];
  int          checks = 0, fails = 0;
  bit          done = 0;
  logic [31:0] mask_m [32];
  logic [31:0] img_m  [32];
  int          cx = 'hF000, cy = 'hF000;
  logic [31:0] misc_m = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model_pix(int x, int y, logic [23:0] pix);
    int dx, dy;
    if (x >= 1024 || y >= 768 || cx >= 1024) return pix;
    dx = x - cx;
    dy = y - cy;
    if (dx < 0 || dx > 31 || dy < 0 || dy > 31) return pix;
    if (mask_m[dy][31-dx]) return img_m[dy][31-dx] ? COL1 : COL0;
    return pix;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
    if (a == 12'h8FC) begin
      cx = int'(d[31:16]); cy = int'(d[15:0]);
    end else if (a >= 12'h900 && a < 12'h980) mask_m[(a - 12'h900) >> 2] = d;
    else if (a >= 12'h980 && a < 12'hA00) img_m[(a - 12'h980) >> 2] = d;
    else if (a == 12'h818) misc_m = d;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr_i = a;
    #1 check(reg_rdata_o == exp, tag, reg_rdata_o, exp);
  endtask

  task automatic drive_pix(input int x, input int y, input string tag);
    item_t it;
    logic [23:0] pc;
    pc = {8'h81, 8'(x), 8'(y)};
    @(negedge clk);
    pix_valid_i = 1'b1; pix_x_i = 16'(x); pix_y_i = 16'(y); pix_color_i = pc;
    it.exp = model_pix(x, y, pc); it.tag = tag; it.x = x; it.y = y;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid_i = 1'b0;
    end
  endtask

  task automatic sweep(input int x0, input int x1, input int y0, input int y1,
                       input string tag);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) drive_pix(x, y, tag);
    idle(2);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && !done && pix_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected valid", {8'h0, pix_color_o}, 32'h0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(pix_color_o == it.exp, it.tag, {8'h0, pix_color_o}, {8'h0, it.exp});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++) begin
      mask_m[r] = '0; img_m[r] = '0;
    end
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    #1 check(pix_valid_o == 1'b0, "R8 valid low after reset", {31'h0, pix_valid_o}, 32'h0);
    rd(12'h818, 32'h0200_0000, "R8 R9 misc reset read");
    rd(12'h8FC, 32'h0, "R10 position reads zero");
    // cursor off screen after reset
    sweep(0, 3, 0, 1, "R8 off-screen cursor");

    // R3: load rows, one write with address bits 1:0 set
    for (int r = 0; r < 32; r++) begin
      logic [11:0] ma;
      ma = 12'(12'h900 + r*4 + ((r == 3) ? 2 : 0));
      wr(ma, 32'hA5C3_0FF0 ^ (32'(r) * 32'h0011_2233));
      wr(12'(12'h980 + r*4), 32'h3333_CCCC ^ (32'(r) * 32'h0101_0101));
    end
    wr(12'h900, 32'h8000_0001);
    wr(12'h980, 32'h8000_0000);
    wr(12'h8FC, {16'd100, 16'd50});
    sweep(100, 100, 50, 50, "R4 leftmost bit31 col1");
    sweep(131, 131, 50, 50, "R4 rightmost bit0 col0");
    sweep(101, 101, 50, 50, "R4 R5 transparent pass");
    sweep(96, 134, 48, 83, "R2 R3 R5 window sweep");

    // R6: top-left corner and no wrap from a high Y
    wr(12'h8FC, {16'd0, 16'd0});
    sweep(0, 33, 30, 33, "R6 window bottom edge");
    wr(12'h8FC, {16'd0, 16'hFFF0});
    sweep(0, 5, 0, 3, "R6 no wrap");

    // R7: right and bottom clipping, cursor X beyond width
    wr(12'h8FC, {16'd1010, 16'd760});
    sweep(1005, 1030, 758, 770, "R7 edge clip");
    wr(12'h8FC, {16'd1024, 16'd10});
    sweep(1020, 1030, 10, 12, "R7 cursor x off screen");

    // R9 misc
    wr(12'h818, 32'h0000_0001);
    rd(12'h818, 32'h0200_0001, "R9 misc low bit");
    wr(12'h818, 32'hFFFF_FFFF);
    rd(12'h818, 32'hFFFF_FFFF, "R9 misc all ones");
    wr(12'h818, 32'h0);
    rd(12'h818, 32'h0200_0000, "R9 misc cleared");

    // R10: stray writes change nothing, other reads zero
    wr(12'h8FC, {16'd0, 16'd0});
    wr(12'h800, 32'h1234_5678);
    wr(12'h8F8, 32'hFFFF_FFFF);
    wr(12'hA00, 32'hFFFF_FFFF);
    rd(12'h818, 32'h0200_0000, "R10 misc untouched");
    rd(12'h900, 32'h0, "R10 mask reads zero");
    rd(12'hA00, 32'h0, "R10 unmapped reads zero");
    sweep(0, 31, 0, 1, "R10 rows untouched");

    // R1 latency and valid drop
    drive_pix(2, 2, "R1 single pixel");
    @(negedge clk);
    pix_valid_i = 1'b0;
    #1 check(pix_valid_o == 1'b1, "R1 valid one cycle later", {31'h0, pix_valid_o}, 32'h1);
    @(negedge clk);
    #1 check(pix_valid_o == 1'b0, "R1 valid drops", {31'h0, pix_valid_o}, 32'h0);
    idle(2);
    check(exp_q.size() == 0, "R1 all pixels returned", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule